// File: doc/BRIEF.md
# Nested Acknowledge and Completion Tracker

This block is the per-processor bookkeeping behind interrupt acknowledge reads and end-of-interrupt writes. An arbiter outside the block presents the highest-pending interrupt ID and its priority. When the processor acknowledges, the tracker decides whether that interrupt may preempt the one now running. If it may, the new interrupt becomes the running one, its priority becomes the running priority, and the pending latch is told to clear it. If it may not, the spurious ID 1023 is returned.

Preemption is remembered through one "previous" link per interrupt ID. Each acknowledge stores the interrupt it displaced in the link of the new ID. Completing the running interrupt pops the chain. Running ID and running priority come back from the link, and the priority is looked up in the priority table. Software may also complete an interrupt that was preempted and is not running. For that case a small walker follows the chain one link per cycle, finds the predecessor of the target and splices the target out. The running interrupt is not touched. The block reports busy during the walk and accepts no request while busy.

Every accepted end-of-interrupt also produces a strobe carrying the completed ID. The pending latch uses it to re-raise a level-sensitive source that is still asserted. Address decoding and the pending latch itself belong to the surrounding logic.

Top module: `nack_tracker`

## Requirements
- R1: After reset, run_id is 1023, run_prio is 0x100, busy is 0, ack_valid is 0, and every link holds 1023.
- R2: An acknowledge request in a non-busy cycle always gives ack_valid one cycle later. If hp_id is 1023 or any ID at or above NUM_IRQ, ack_id is 1023, run_id and run_prio are unchanged and clr_valid stays 0.
- R3: If hp_prio is not strictly below run_prio (an equal value included), an acknowledge returns 1023 and changes nothing.
- R4: A successful acknowledge stores the old run_id in the link of hp_id. One cycle after the request, ack_id and run_id equal hp_id, run_prio equals hp_prio with a zero top bit, and clr_valid pulses with clr_id equal to hp_id.
- R5: Completing the running ID sets run_id to that ID's link. run_prio becomes the priority-table entry of the new run_id, or 0x100 when the link is 1023. Both take effect one cycle after the request.
- R6: An end-of-interrupt whose ID is at or above NUM_IRQ (1023 included) is ignored. Nothing changes, busy stays 0 and retrig_valid stays 0.
- R7: An end-of-interrupt while run_id is 1023 is ignored, with no strobe.
- R8: Completing a preempted, non-running ID leaves run_id and run_prio unchanged. It removes the ID from the chain, so later completions of the running interrupts skip over it.
- R9: Completing an ID that is not in the chain leaves the chain and the running state unchanged. The walk ends when it reads link 1023.
- R10: busy is 1 from the cycle after a non-running completion is accepted until the walk ends. Acknowledge and end-of-interrupt requests seen while busy have no effect, and an acknowledge gives no ack_valid.
- R11: When an acknowledge and an end-of-interrupt arrive in the same non-busy cycle, the acknowledge is served and the end-of-interrupt is dropped.
- R12: Each accepted end-of-interrupt (ID below NUM_IRQ while something runs) pulses retrig_valid one cycle later, with retrig_id equal to the completed ID.
- R13: A walk ends after at most NUM_IRQ busy cycles even if the chain contains a loop, and run_id is unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_req | input | 1 | Acknowledge request, one cycle |
| hp_id | input | 10 | Highest-pending ID from the arbiter |
| hp_prio | input | PRIO_W | Priority of hp_id (lower is more urgent) |
| eoi_valid | input | 1 | End-of-interrupt request, one cycle |
| eoi_id | input | 10 | ID being completed |
| prio_table | input | NUM_IRQ*PRIO_W | Priority of each ID, ID n at bits n*PRIO_W upward |
| busy | output | 1 | Chain walk in progress |
| ack_valid | output | 1 | Acknowledge answer strobe |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| run_id | output | 10 | Running ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| clr_valid | output | 1 | Clear-pending strobe to the pending latch |
| clr_id | output | 10 | ID to clear |
| retrig_valid | output | 1 | Completion strobe for level re-pending |
| retrig_id | output | 10 | Completed ID |

## Verification
Nested acknowledges with falling priorities build a chain of four. That chain is unwound in three ways: from the head, from the middle, and with an ID that is absent from it. These show whether a splice, rather than a pop, took place. Equal priority, the spurious ID and out-of-range IDs separate the strict comparison from the range checks. Simultaneous requests and requests made during a walk show the request ordering and the busy gating. A deliberately looping chain shows that the walk is bounded. A seeded random mix of acknowledges and completions, targeting chain members, non-members and invalid IDs, is then compared with a reference chain model.

// File: rtl/nack_pkg.sv
package nack_pkg;
    localparam int unsigned ID_W = 10;
    localparam logic [ID_W-1:0] NO_ID = 10'd1023;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;
endpackage

// File: rtl/nack_link_store.sv
module nack_link_store import nack_pkg::*; #(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] rd_a_id,
    output logic [ID_W-1:0] rd_a_data,
    input  logic [ID_W-1:0] rd_b_id,
    output logic [ID_W-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic [ID_W-1:0] wr_data
);
    localparam int unsigned IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);

    logic [ID_W-1:0] links_q [NUM_IRQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                links_q[i] <= NO_ID;
            end
        end else if (wr_en && (wr_id < LIMIT)) begin
            links_q[wr_id[IDX_W-1:0]] <= wr_data;
        end
    end

    // Out-of-range reads behave like an empty link.
    always_comb begin
        rd_a_data = NO_ID;
        rd_b_data = NO_ID;
        if (rd_a_id < LIMIT) begin
            rd_a_data = links_q[rd_a_id[IDX_W-1:0]];
        end
        if (rd_b_id < LIMIT) begin
            rd_b_data = links_q[rd_b_id[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/nack_prio_pick.sv
module nack_prio_pick import nack_pkg::*; #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8
) (
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_table,
    input  logic [ID_W-1:0]           id,
    output logic [PRIO_W:0]           prio
);
    localparam int unsigned IDX_W = $clog2(NUM_IRQ);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(NUM_IRQ);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    logic [PRIO_W-1:0] entry [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_entry
        assign entry[g] = prio_table[g*PRIO_W +: PRIO_W];
    end

    always_comb begin
        prio = IDLE_PRIO;
        if (id < LIMIT) begin
            prio = {1'b0, entry[id[IDX_W-1:0]]};
        end
    end
endmodule

// File: rtl/nack_tracker.sv
module nack_tracker import nack_pkg::*; #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ack_req,
    input  logic [ID_W-1:0]           hp_id,
    input  logic [PRIO_W-1:0]         hp_prio,
    input  logic                      eoi_valid,
    input  logic [ID_W-1:0]           eoi_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_table,
    output logic                      busy,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic [ID_W-1:0]           run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      clr_valid,
    output logic [ID_W-1:0]           clr_id,
    output logic                      retrig_valid,
    output logic [ID_W-1:0]           retrig_id
);
    localparam logic [ID_W-1:0]   LIMIT     = ID_W'(NUM_IRQ);
    localparam logic [PRIO_W:0]   IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
    localparam int unsigned       STEP_W    = $clog2(NUM_IRQ + 1);
    localparam logic [STEP_W-1:0] STEP_MAX  = STEP_W'(NUM_IRQ - 1);

    typedef struct packed {
        walk_state_e       state;
        logic [ID_W-1:0]   run_id;
        logic [PRIO_W:0]   run_prio;
        logic [ID_W-1:0]   cur;
        logic [ID_W-1:0]   target;
        logic [STEP_W-1:0] steps;
        logic              ack_valid;
        logic [ID_W-1:0]   ack_id;
        logic              clr_valid;
        logic [ID_W-1:0]   clr_id;
        logic              retrig_valid;
        logic [ID_W-1:0]   retrig_id;
    } trk_t;

    localparam trk_t TRK_RST = '{
        state:        ST_IDLE,
        run_id:       NO_ID,
        run_prio:     IDLE_PRIO,
        cur:          NO_ID,
        target:       NO_ID,
        steps:        '0,
        ack_valid:    1'b0,
        ack_id:       NO_ID,
        clr_valid:    1'b0,
        clr_id:       NO_ID,
        retrig_valid: 1'b0,
        retrig_id:    NO_ID
    };

    trk_t            trk_d, trk_q;
    logic [ID_W-1:0] rd_a_id, rd_a_data, rd_b_id, rd_b_data;
    logic            wr_en;
    logic [ID_W-1:0] wr_id, wr_data;
    logic [PRIO_W:0] restore_prio;
    logic            ack_ok, eoi_ok;

    nack_link_store #(.NUM_IRQ(NUM_IRQ)) i_links (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_id   (rd_a_id),
        .rd_a_data (rd_a_data),
        .rd_b_id   (rd_b_id),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_id     (wr_id),
        .wr_data   (wr_data)
    );

    // Priority of the interrupt that a pop would resume.
    nack_prio_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_restore (
        .prio_table (prio_table),
        .id         (rd_a_data),
        .prio       (restore_prio)
    );

    assign rd_a_id = (trk_q.state == ST_WALK) ? trk_q.cur : trk_q.run_id;
    assign rd_b_id = trk_q.target;

    assign ack_ok = (hp_id < LIMIT) && ({1'b0, hp_prio} < trk_q.run_prio);
    assign eoi_ok = (eoi_id < LIMIT) && (trk_q.run_id != NO_ID);

    always_comb begin
        trk_d              = trk_q;
        trk_d.ack_valid    = 1'b0;
        trk_d.clr_valid    = 1'b0;
        trk_d.retrig_valid = 1'b0;
        wr_en              = 1'b0;
        wr_id              = hp_id;
        wr_data            = trk_q.run_id;

        unique case (trk_q.state)
            ST_IDLE: begin
                if (ack_req) begin
                    trk_d.ack_valid = 1'b1;
                    trk_d.ack_id    = NO_ID;
                    if (ack_ok) begin
                        wr_en          = 1'b1;
                        trk_d.ack_id   = hp_id;
                        trk_d.run_id   = hp_id;
                        trk_d.run_prio = {1'b0, hp_prio};
                        trk_d.clr_valid = 1'b1;
                        trk_d.clr_id   = hp_id;
                    end
                end else if (eoi_valid && eoi_ok) begin
                    trk_d.retrig_valid = 1'b1;
                    trk_d.retrig_id    = eoi_id;
                    if (eoi_id == trk_q.run_id) begin
                        trk_d.run_id   = rd_a_data;
                        trk_d.run_prio = restore_prio;
                    end else begin
                        trk_d.state  = ST_WALK;
                        trk_d.cur    = trk_q.run_id;
                        trk_d.target = eoi_id;
                        trk_d.steps  = '0;
                    end
                end
            end
            ST_WALK: begin
                if ((rd_a_data == NO_ID) || (trk_q.steps == STEP_MAX)) begin
                    trk_d.state = ST_IDLE;
                end else if (rd_a_data == trk_q.target) begin
                    wr_en       = 1'b1;
                    wr_id       = trk_q.cur;
                    wr_data     = rd_b_data;
                    trk_d.state = ST_IDLE;
                end else begin
                    trk_d.cur   = rd_a_data;
                    trk_d.steps = trk_q.steps + 1'b1;
                end
            end
            default: trk_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= TRK_RST;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign busy         = (trk_q.state == ST_WALK);
    assign ack_valid    = trk_q.ack_valid;
    assign ack_id       = trk_q.ack_id;
    assign run_id       = trk_q.run_id;
    assign run_prio     = trk_q.run_prio;
    assign clr_valid    = trk_q.clr_valid;
    assign clr_id       = trk_q.clr_id;
    assign retrig_valid = trk_q.retrig_valid;
    assign retrig_id    = trk_q.retrig_id;
endmodule

// File: rtl/nack_tracker_chk.sv
module nack_tracker_chk import nack_pkg::*; #(
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned PRIO_W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_req,
    input logic            eoi_valid,
    input logic [ID_W-1:0] eoi_id,
    input logic            busy,
    input logic            ack_valid,
    input logic [ID_W-1:0] ack_id,
    input logic [ID_W-1:0] run_id,
    input logic [PRIO_W:0] run_prio,
    input logic            clr_valid,
    input logic [ID_W-1:0] clr_id,
    input logic            retrig_valid
);
    localparam logic [ID_W-1:0] LIMIT     = ID_W'(NUM_IRQ);
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    // R1
    idle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == NO_ID) == (run_prio == IDLE_PRIO));

    // R4
    ack_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != NO_ID) |-> (run_id == ack_id) && (run_prio < $past(run_prio)));

    // R4
    clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (ack_valid && clr_id == ack_id && ack_id != NO_ID));

    // R10
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_valid);

    // R8
    walk_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (run_id == $past(run_id)) && (run_prio == $past(run_prio)));

    // R6
    eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !busy && !ack_req && eoi_id >= LIMIT) |=>
            (run_id == $past(run_id)) && !retrig_valid && !busy);

    // R7
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !busy && !ack_req && run_id == NO_ID) |=>
            (run_id == NO_ID) && !retrig_valid && !busy);
endmodule

bind nack_tracker nack_tracker_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_req      (ack_req),
    .eoi_valid    (eoi_valid),
    .eoi_id       (eoi_id),
    .busy         (busy),
    .ack_valid    (ack_valid),
    .ack_id       (ack_id),
    .run_id       (run_id),
    .run_prio     (run_prio),
    .clr_valid    (clr_valid),
    .clr_id       (clr_id),
    .retrig_valid (retrig_valid)
);

// File: tb/test_nack_tracker.sv
`timescale 1ns/1ps
module test_nack_tracker;
    localparam int NI = 64;
    localparam int PW = 8;
    localparam int NOID = 1023;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ack_req = 1'b0;
    logic [9:0]     hp_id = 10'd1023;
    logic [PW-1:0]  hp_prio = '0;
    logic           eoi_valid = 1'b0;
    logic [9:0]     eoi_id = 10'd0;
    logic [NI*PW-1:0] prio_table;
    logic           busy, ack_valid, clr_valid, retrig_valid;
    logic [9:0]     ack_id, run_id, clr_id, retrig_id;
    logic [PW:0]    run_prio;

    logic [7:0] tbl [NI];
    int m_link [NI];
    int m_run;
    int m_prio;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NI; i++) prio_table[i*PW +: PW] = tbl[i];
    end

    nack_tracker #(.NUM_IRQ(NI), .PRIO_W(PW)) i_nack_tracker (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
        .hp_prio(hp_prio), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .prio_table(prio_table), .busy(busy), .ack_valid(ack_valid),
        .ack_id(ack_id), .run_id(run_id), .run_prio(run_prio),
        .clr_valid(clr_valid), .clr_id(clr_id),
        .retrig_valid(retrig_valid), .retrig_id(retrig_id)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            finish_run();
        end
    end

    function automatic bit in_chain(int id);
        int cur = m_run;
        for (int n = 0; n < NI && cur != NOID; n++) begin
            if (cur == id) return 1'b1;
            cur = m_link[cur];
        end
        return 1'b0;
    endfunction

    task automatic do_ack(string req, int id, int pr);
        bit ok;
        ok = (id < NI) && (pr < m_prio);
        @(negedge clk);
        ack_req = 1'b1; hp_id = id[9:0]; hp_prio = pr[PW-1:0];
        @(negedge clk);
        ack_req = 1'b0;
        chk(req, "ack_valid", int'(ack_valid), 1);
        chk(req, "ack_id", int'(ack_id), ok ? id : NOID);
        chk(req, "clr_valid", int'(clr_valid), int'(ok));
        if (ok) begin
            chk(req, "clr_id", int'(clr_id), id);
            m_link[id] = m_run;
            m_run = id;
            m_prio = pr;
        end
        chk(req, "run_id", int'(run_id), m_run);
        chk(req, "run_prio", int'(run_prio), m_prio);
    endtask

    task automatic do_eoi(string req, int id);
        bit acc, walk;
        int cur, nxt, lim;
        acc  = (id < NI) && (m_run != NOID);
        walk = acc && (id != m_run);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = id[9:0];
        @(negedge clk);
        eoi_valid = 1'b0;
        chk(req, "retrig_valid (R12)", int'(retrig_valid), int'(acc));
        if (acc) chk(req, "retrig_id (R12)", int'(retrig_id), id);
        chk(req, "busy (R10)", int'(busy), int'(walk));
        if (acc && !walk) begin
            m_run = m_link[id];
            m_prio = (m_run == NOID) ? 256 : int'(tbl[m_run]);
        end else if (walk) begin
            cur = m_run;
            for (int s = 0; ; s++) begin
                nxt = m_link[cur];
                if (nxt == NOID || s == NI - 1) break;
                if (nxt == id) begin
                    m_link[cur] = m_link[id];
                    break;
                end
                cur = nxt;
            end
        end
        lim = 0;
        while (busy && lim < NI + 4) begin
            @(negedge clk);
            lim++;
        end
        chk(req, "walk ends (R13)", int'(lim <= NI), 1);
        chk(req, "run_id", int'(run_id), m_run);
        chk(req, "run_prio", int'(run_prio), m_prio);
    endtask

    initial begin
        int op, id, pick, cur, depth;
        void'($urandom(32'd1234));
        for (int i = 0; i < NI; i++) begin
            tbl[i] = 8'($urandom_range(0, 255));
            m_link[i] = NOID;
        end
        tbl[10] = 8'd40; tbl[11] = 8'd30; tbl[12] = 8'd20;
        tbl[13] = 8'd10; tbl[14] = 8'd40; tbl[20] = 8'd50;
        m_run = NOID; m_prio = 256;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "run_id", int'(run_id), NOID);
        chk("R1", "run_prio", int'(run_prio), 256);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "ack_valid", int'(ack_valid), 0);

        do_eoi("R7", 5);
        do_ack("R2", NOID, 3);
        do_ack("R2", 70, 3);

        do_ack("R4", 10, 40);
        do_ack("R3", 14, 40);
        do_ack("R4", 11, 30);
        do_ack("R4", 12, 20);
        do_ack("R4", 13, 10);
        do_eoi("R6", 70);
        do_eoi("R6", NOID);

        // R10: remove 11 from the middle; an acknowledge during the walk is dropped
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = 10'd11;
        @(negedge clk);
        eoi_valid = 1'b0;
        chk("R10", "busy", int'(busy), 1);
        ack_req = 1'b1; hp_id = 10'd20; hp_prio = 8'd0;
        @(negedge clk);
        ack_req = 1'b0;
        chk("R10", "ack_valid while busy", int'(ack_valid), 0);
        while (busy) @(negedge clk);
        m_link[12] = 10;
        chk("R8", "run_id after splice", int'(run_id), 13);
        chk("R8", "run_prio after splice", int'(run_prio), 10);

        do_eoi("R9", 15);
        do_eoi("R5", 13);
        do_eoi("R8", 12);
        chk("R8", "skipped to 10", int'(run_id), 10);
        do_eoi("R5", 10);
        chk("R5", "idle prio", int'(run_prio), 256);

        // R11: simultaneous acknowledge and completion
        do_ack("R4", 10, 40);
        @(negedge clk);
        ack_req = 1'b1; hp_id = 10'd13; hp_prio = 8'd10;
        eoi_valid = 1'b1; eoi_id = 10'd10;
        @(negedge clk);
        ack_req = 1'b0; eoi_valid = 1'b0;
        chk("R11", "ack_id", int'(ack_id), 13);
        chk("R11", "run_id", int'(run_id), 13);
        chk("R11", "retrig_valid", int'(retrig_valid), 0);
        chk("R11", "busy", int'(busy), 0);
        m_link[13] = 10; m_run = 13; m_prio = 10;
        do_eoi("R5", 13);
        do_eoi("R5", 10);

        // mixed random traffic
        for (int it = 0; it < 400; it++) begin
            op = int'($urandom_range(0, 99));
            if (op < 50) begin
                id = int'($urandom_range(0, NI - 1));
                if (in_chain(id)) id = NOID;
                if (op < 4) id = int'($urandom_range(NI, NOID));
                do_ack("R4", id, (id < NI) ? int'(tbl[id]) : 0);
            end else if (op < 85) begin
                depth = 0;
                cur = m_run;
                while (cur != NOID && depth < NI) begin
                    depth++;
                    cur = m_link[cur];
                end
                if (depth == 0) begin
                    do_eoi("R7", int'($urandom_range(0, NI - 1)));
                end else begin
                    pick = int'($urandom_range(0, depth - 1));
                    cur = m_run;
                    for (int k = 0; k < pick; k++) cur = m_link[cur];
                    do_eoi("R8", cur);
                end
            end else if (op < 93) begin
                id = int'($urandom_range(0, NI - 1));
                if (!in_chain(id)) do_eoi("R9", id);
            end else begin
                do_eoi("R6", int'($urandom_range(NI, NOID)));
            end
        end

        // R13: a chain that points to itself; the walk must still end
        while (m_run != NOID) do_eoi("R5", m_run);
        do_ack("R13", 20, 50);
        do_ack("R13", 20, 5);
        do_eoi("R13", 21);
        chk("R13", "run_id after looping walk", int'(run_id), 20);
        finish_run();
    end
endmodule